// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

This block is a small processor that runs every instruction as a fixed series of register-transfer steps. A program counter, a memory address register, a memory data register, an instruction register, an 8-bit accumulator and four 8-bit general registers move data between them. It uses one synchronous memory of 16-bit words, which returns read data in the cycle after the read strobe. The address always comes from the memory address register, and write data always comes from the memory data register.

The core fetches a word in four steps: it loads the address register, issues the read, captures the word while the program counter advances, and then loads the instruction register. Decode and execute follow. Write-back comes last. A load adds a second memory read and one cycle more to move the captured byte into the accumulator. Two byte-wide input ports and two registered byte-wide output ports serve the port instructions. A halt instruction parks the core until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: Fetch timing, counted in cycles from the first step of an instruction:
  - cycle 0 copies PC into the address register;
  - cycle 1 asserts `mem_rd` with `mem_addr` equal to PC;
  - cycle 2 captures the returned word and increments PC by one (mod 256);
  - cycle 3 loads the instruction register;
  - cycle 4 decodes.
- R2: Instruction word layout: opcode in [15:12], first register in [11:10], second register in [9:8], address or immediate in [7:0]. Opcodes are ADD=0, SUB=1, LD=2, ST=3, JMP=4, BRZ=5, IN=6, OUT=7 and HALT=F. The opcodes 8 to E are no-ops: the core goes back to fetch right after decode, so such an instruction takes 5 cycles.
- R3: ADD writes first+second register into the first register. SUB writes the first register minus the 8-bit immediate into it. Both wrap modulo 256, are written in cycle 6, and the instruction takes 7 cycles.
- R4: LD asserts `mem_rd` in cycle 5 with `mem_addr` equal to the address field. The returned byte (word bits [7:0]) reaches the accumulator in cycle 7, and the instruction takes 8 cycles.
- R5: ST asserts `mem_wr` for exactly cycle 5, with `mem_addr` equal to the address field and `mem_wdata` = {8'h00, accumulator}. `mem_rd` and `mem_wr` are never high together.
- R6: JMP makes the next fetch address the address field. BRZ does the same only when its first register is zero; otherwise fetch continues at PC+1. Both take 7 cycles.
- R7: Field bit 0 selects the port: 0 for port a, 1 for port b.
  - IN writes the selected input port, sampled in cycle 5, into the first register.
  - OUT loads the accumulator into the selected output port in cycle 5, visible from cycle 6. The other output port is left unchanged.
- R8: HALT raises `halted` from cycle 6 onward. After that, no memory strobe is asserted and all outputs hold until reset.
- R9: Synchronous active-high reset clears PC, the address register, the accumulator, all general registers, both output ports and `halted`. The first cycle after reset is cycle 0 of a fetch from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| in_port_a | input | 8 | Input port a |
| in_port_b | input | 8 | Input port b |
| out_port_a | output | 8 | Registered output port a |
| out_port_b | output | 8 | Registered output port b |
| halted | output | 1 | High once a halt has executed |

## Verification
The test programs make the main flow depend on register values. They include:
- branches that are taken and branches that fall through, on values built by ADD and SUB, including a subtraction that wraps below zero;
- a store followed by a load from the same address;
- output writes to both ports with different contents, so a swapped port select or a lost write shows up at once;
- an undefined opcode placed between live instructions, which separates a true skip from a stray execute;
- a second program after a reset issued while halted, which tells cleared registers and accumulator apart from values left over.

A cycle-level model predicts every strobe, address and port value, so an off-by-one step shows as a timing mismatch, not just a wrong end result.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int OPC_W  = 4;
    localparam int RSEL_W = 2;
    localparam int NREG   = 1 << RSEL_W;
    localparam int INSN_W = OPC_W + 2 * RSEL_W + ADDR_W;
    localparam int PAD_W  = INSN_W - DATA_W;

    localparam logic [OPC_W-1:0] OP_ADD  = 4'h0;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'h1;
    localparam logic [OPC_W-1:0] OP_LD   = 4'h2;
    localparam logic [OPC_W-1:0] OP_ST   = 4'h3;
    localparam logic [OPC_W-1:0] OP_JMP  = 4'h4;
    localparam logic [OPC_W-1:0] OP_BRZ  = 4'h5;
    localparam logic [OPC_W-1:0] OP_IN   = 4'h6;
    localparam logic [OPC_W-1:0] OP_OUT  = 4'h7;
    localparam logic [OPC_W-1:0] OP_HALT = 4'hF;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RSEL_W-1:0] ra;
        logic [RSEL_W-1:0] rb;
        logic [ADDR_W-1:0] fld;
    } insn_t;

    typedef enum logic [3:0] {
        PH_FADR  = 4'd0,
        PH_FRD   = 4'd1,
        PH_FCAP  = 4'd2,
        PH_FIR   = 4'd3,
        PH_DEC   = 4'd4,
        PH_EXE   = 4'd5,
        PH_WB    = 4'd6,
        PH_LDACC = 4'd7,
        PH_HALT  = 4'd8
    } phase_e;

    function automatic logic opc_known(input logic [OPC_W-1:0] o);
        return (o <= OP_OUT) || (o == OP_HALT);
    endfunction

    function automatic logic opc_writes_reg(input logic [OPC_W-1:0] o);
        return (o == OP_ADD) || (o == OP_SUB) || (o == OP_IN);
    endfunction

    function automatic logic opc_uses_mem(input logic [OPC_W-1:0] o);
        return (o == OP_LD) || (o == OP_ST);
    endfunction

endpackage

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile
    import acc_cpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = RSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [SW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int NR = 1 << SW;

    logic [NR-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NR; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (waddr == SW'(g))) begin
                q <= wdata;
            end
        end
        assign bank[g] = q;
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

    // R3
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (bank[$past(waddr)] == $past(wdata)))
        else $error("register write lost");

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opc,
    output phase_e           phase
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_FADR:  nxt = PH_FRD;
            PH_FRD:   nxt = PH_FCAP;
            PH_FCAP:  nxt = PH_FIR;
            PH_FIR:   nxt = PH_DEC;
            PH_DEC:   nxt = opc_known(opc) ? PH_EXE : PH_FADR;
            PH_EXE:   nxt = (opc == OP_HALT) ? PH_HALT : PH_WB;
            PH_WB:    nxt = (opc == OP_LD) ? PH_LDACC : PH_FADR;
            PH_LDACC: nxt = PH_FADR;
            PH_HALT:  nxt = PH_HALT;
            default:  nxt = PH_FADR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FADR;
        else     phase <= nxt;
    end

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HALT) |=> (phase == PH_HALT))
        else $error("left halt without reset");

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [INSN_W-1:0] mem_wdata,
    input  logic [INSN_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] in_port_a,
    input  logic [DATA_W-1:0] in_port_b,
    output logic [DATA_W-1:0] out_port_a,
    output logic [DATA_W-1:0] out_port_b,
    output logic              halted
);
    phase_e            phase;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [INSN_W-1:0] mdr;
    insn_t             ir;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] outa_q;
    logic [DATA_W-1:0] outb_q;
    logic [DATA_W-1:0] rf_a;
    logic [DATA_W-1:0] rf_b;
    logic [DATA_W-1:0] alu_y;
    logic              rf_we;
    logic              port_sel;

    acc_cpu_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .opc   (ir.opc),
        .phase (phase)
    );

    acc_cpu_regfile #(.DW(DATA_W), .SW(RSEL_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (ir.ra),
        .wdata   (res),
        .raddr_a (ir.ra),
        .rdata_a (rf_a),
        .raddr_b (ir.rb),
        .rdata_b (rf_b)
    );

    acc_cpu_alu #(.DW(DATA_W)) u_alu (
        .sub (ir.opc == OP_SUB),
        .a   (opa),
        .b   (opb),
        .y   (alu_y)
    );

    assign port_sel = ir.fld[0];
    assign rf_we    = (phase == PH_WB) && opc_writes_reg(ir.opc);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            mar    <= '0;
            mdr    <= '0;
            ir     <= '0;
            acc    <= '0;
            opa    <= '0;
            opb    <= '0;
            res    <= '0;
            outa_q <= '0;
            outb_q <= '0;
        end else begin
            case (phase)
                PH_FADR: mar <= pc;
                PH_FCAP: begin
                    mdr <= mem_rdata;
                    pc  <= pc + 1'b1;
                end
                PH_FIR: ir <= mdr;
                PH_DEC: begin
                    opa <= rf_a;
                    opb <= (ir.opc == OP_SUB) ? ir.fld : rf_b;
                    if (opc_uses_mem(ir.opc)) mar <= ir.fld;
                    if (ir.opc == OP_ST) mdr <= {{PAD_W{1'b0}}, acc};
                end
                PH_EXE: begin
                    case (ir.opc)
                        OP_ADD, OP_SUB: res <= alu_y;
                        OP_IN:  res <= port_sel ? in_port_b : in_port_a;
                        OP_JMP: pc  <= ir.fld;
                        OP_BRZ: if (opa == '0) pc <= ir.fld;
                        OP_OUT: begin
                            if (port_sel) outb_q <= acc;
                            else          outa_q <= acc;
                        end
                        default: ;
                    endcase
                end
                PH_WB: if (ir.opc == OP_LD) mdr <= mem_rdata;
                PH_LDACC: acc <= mdr[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    assign mem_addr   = mar;
    assign mem_wdata  = mdr;
    assign mem_rd     = (phase == PH_FRD) || ((phase == PH_EXE) && (ir.opc == OP_LD));
    assign mem_wr     = (phase == PH_EXE) && (ir.opc == OP_ST);
    assign out_port_a = outa_q;
    assign out_port_b = outb_q;
    assign halted     = (phase == PH_HALT);

    // R1
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FRD) |-> (mem_rd && (mem_addr == pc)))
        else $error("fetch address differs from PC");

    // R1
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FCAP) |=> (pc == $past(pc) + 1'b1))
        else $error("PC did not advance after capture");

    // R5
    store_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == {{PAD_W{1'b0}}, acc}))
        else $error("store data is not the accumulator");

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr))
        else $error("read and write together");

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_EXE) && (ir.opc == OP_JMP)) |=> (pc == $past(ir.fld)))
        else $error("jump target not taken");

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr && $stable(out_port_a) && $stable(out_port_b)))
        else $error("activity while halted");

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [7:0]  in_port_a;
    logic [7:0]  in_port_b;
    logic [7:0]  out_port_a;
    logic [7:0]  out_port_b;
    logic        halted;

    always #2 clk = ~clk;

    acc_cpu_core dut (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .in_port_a  (in_port_a),
        .in_port_b  (in_port_b),
        .out_port_a (out_port_a),
        .out_port_b (out_port_b),
        .halted     (halted)
    );

    // bench memory: one-cycle read latency
    logic [15:0] bmem [256];
    logic [15:0] rdata_q = 16'h0;
    always @(posedge clk) begin
        if (mem_rd) rdata_q <= bmem[mem_addr];
        if (mem_wr) bmem[mem_addr] <= mem_wdata;
    end
    assign mem_rdata = rdata_q;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int          mk;
    logic [7:0]  m_pc, m_mar, m_acc, m_oa, m_ob, m_res, m_ldv;
    logic [15:0] m_ir, m_fetched;
    logic [7:0]  m_reg [4];
    bit          m_halt;
    logic [15:0] mmem [256];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 16'h0;
            mmem[i] = 16'h0;
        end
    endtask

    task automatic poke(input int a, input logic [15:0] w);
        bmem[a] = w;
        mmem[a] = w;
    endtask

    task automatic model_reset();
        mk = 0; m_pc = 0; m_mar = 0; m_acc = 0; m_oa = 0; m_ob = 0;
        m_res = 0; m_ldv = 0; m_ir = 0; m_fetched = 0; m_halt = 0;
        for (int i = 0; i < 4; i++) m_reg[i] = 0;
    endtask

    task automatic model_step();
        logic [3:0] op;
        logic [1:0] d, s;
        logic [7:0] f;
        op = m_ir[15:12]; d = m_ir[11:10]; s = m_ir[9:8]; f = m_ir[7:0];
        case (mk)
            0: begin m_mar = m_pc; mk = 1; end
            1: mk = 2;
            2: begin m_fetched = mmem[m_mar]; m_pc = m_pc + 8'd1; mk = 3; end
            3: begin m_ir = m_fetched; mk = 4; end
            4: begin
                if (!((op <= 4'h7) || (op == 4'hF))) mk = 0;
                else begin
                    if (op == 4'h2 || op == 4'h3) m_mar = f;
                    mk = 5;
                end
            end
            5: begin
                mk = 6;
                case (op)
                    4'h0: m_res = m_reg[d] + m_reg[s];
                    4'h1: m_res = m_reg[d] - f;
                    4'h2: m_ldv = mmem[m_mar][7:0];
                    4'h3: mmem[m_mar] = {8'h00, m_acc};
                    4'h4: m_pc = f;
                    4'h5: if (m_reg[d] == 8'h0) m_pc = f;
                    4'h6: m_res = f[0] ? in_port_b : in_port_a;
                    4'h7: if (f[0]) m_ob = m_acc; else m_oa = m_acc;
                    4'hF: begin m_halt = 1; mk = 8; end
                    default: ;
                endcase
            end
            6: begin
                if (op == 4'h0 || op == 4'h1 || op == 4'h6) m_reg[d] = m_res;
                mk = (op == 4'h2) ? 7 : 0;
            end
            7: begin m_acc = m_ldv; mk = 0; end
            default: ;
        endcase
    endtask

    task automatic compare_cycle();
        logic [3:0] op;
        logic erd, ewr;
        op  = m_ir[15:12];
        erd = (mk == 1) || (mk == 5 && op == 4'h2);
        ewr = (mk == 5 && op == 4'h3);
        chk("R1/R4", "mem_rd", {31'b0, mem_rd}, {31'b0, erd});
        chk("R5", "mem_wr", {31'b0, mem_wr}, {31'b0, ewr});
        chk("R1/R2/R3/R4/R6", "mem_addr", {24'b0, mem_addr}, {24'b0, m_mar});
        if (ewr) chk("R5", "mem_wdata", {16'b0, mem_wdata}, {24'b0, m_acc});
        chk("R7", "out_port_a", {24'b0, out_port_a}, {24'b0, m_oa});
        chk("R7", "out_port_b", {24'b0, out_port_b}, {24'b0, m_ob});
        chk("R8", "halted", {31'b0, halted}, {31'b0, m_halt});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        // R9: state right after reset
        chk("R9", "reset out_port_a", {24'b0, out_port_a}, 32'h0);
        chk("R9", "reset out_port_b", {24'b0, out_port_b}, 32'h0);
        chk("R9", "reset halted", {31'b0, halted}, 32'h0);
        chk("R9", "reset mem_addr", {24'b0, mem_addr}, 32'h0);
        chk("R9", "reset strobes", {30'b0, mem_rd, mem_wr}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic run_program(input int max_cycles);
        int extra;
        extra = 0;
        for (int c = 0; c < max_cycles && extra < 12; c++) begin
            compare_cycle();
            model_step();
            if (m_halt) extra++;
            @(negedge clk);
        end
        chk("R8", "halt reached", {31'b0, halted}, 32'h1);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_port_a = 8'h05;
        in_port_b = 8'h13;

        // program A: branches, wrap, store/load, ports, undefined opcode
        clear_mem();
        poke(8'h00, 16'h6400); // IN R1, a
        poke(8'h01, 16'h1405); // SUB R1, #5 -> 0
        poke(8'h02, 16'h5405); // BRZ R1, 05 (taken)
        poke(8'h03, 16'h7000);
        poke(8'h04, 16'hF000);
        poke(8'h05, 16'h2040); // LD 40
        poke(8'h06, 16'h7001); // OUT b
        poke(8'h07, 16'h3041); // ST 41
        poke(8'h08, 16'h6801); // IN R2, b
        poke(8'h09, 16'h0A00); // ADD R2, R2
        poke(8'h0A, 16'h1826); // SUB R2, #26 -> 0
        poke(8'h0B, 16'h580E); // BRZ R2, 0E (taken)
        poke(8'h0C, 16'hF000);
        poke(8'h0D, 16'hF000);
        poke(8'h0E, 16'h8000); // undefined: no-op
        poke(8'h0F, 16'h2041); // LD 41
        poke(8'h10, 16'h6000); // IN R0, a
        poke(8'h11, 16'h1006); // SUB R0, #6 -> FF
        poke(8'h12, 16'h5014); // BRZ R0, 14 (not taken)
        poke(8'h13, 16'h6400); // IN R1, a
        poke(8'h14, 16'h0100); // ADD R0, R1 -> 04
        poke(8'h15, 16'h1004); // SUB R0, #4 -> 0
        poke(8'h16, 16'h5018); // BRZ R0, 18 (taken)
        poke(8'h17, 16'hF000);
        poke(8'h18, 16'h7000); // OUT a
        poke(8'h19, 16'h401B); // JMP 1B
        poke(8'h1A, 16'hF000);
        poke(8'h1B, 16'hF000); // HALT
        poke(8'h40, 16'h00A7);

        do_reset();
        run_program(2000);
        // R5: store landed in memory
        chk("R5", "stored word", {16'b0, bmem[8'h41]}, 32'h00A7);
        // R4: load of stored byte reached port a
        chk("R4", "out_port_a final", {24'b0, out_port_a}, 32'hA7);
        chk("R7", "out_port_b final", {24'b0, out_port_b}, 32'hA7);
        // R3/R6: halt fetched from 1B only if every arithmetic branch went right
        chk("R3/R6", "halt address", {24'b0, mem_addr}, 32'h1B);

        // program B after reset while halted: registers and accumulator cleared
        clear_mem();
        poke(8'h00, 16'h4003); // JMP 03
        poke(8'h03, 16'h5406); // BRZ R1, 06 (taken only if reset cleared R1)
        poke(8'h04, 16'hF000);
        poke(8'h06, 16'h3011); // ST 11 (accumulator must be 0)
        poke(8'h07, 16'h2010); // LD 10
        poke(8'h08, 16'h7000); // OUT a
        poke(8'h09, 16'hF000);
        poke(8'h10, 16'h0055);
        poke(8'h11, 16'hFFFF);

        do_reset();
        run_program(2000);
        chk("R9", "cleared accumulator stored", {16'b0, bmem[8'h11]}, 32'h0000);
        chk("R9", "halt address after reset", {24'b0, mem_addr}, 32'h09);
        chk("R4", "loaded byte on port a", {24'b0, out_port_a}, 32'h55);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule